// File: doc/BRIEF.md
# Dual-Bank Flash Access Guard

This block sits in front of a main flash array built from two physical banks. It sees every access the system makes to that array. Each access carries a logical address and a type: read, write, erase or instruction fetch. The block turns the logical address into a physical one and decides whether the access may proceed. Only granted accesses are forwarded to the array. A denied access raises a one-cycle violation flag, together with the offending address and type.

Two small configuration registers control the mapping and the permissions. The first is a swap-policy enable, which only accepts a write that carries the correct key. The second is a bank select, which chooses the physical bank that appears as logical bank 0.

A single init-done event divides time into two phases:

- **Boot phase.** Every access to the whole array is allowed.
- **Run phase (policy enabled).** Logical bank 0 is the executing bank and may only be read or fetched from. Logical bank 1 may be read, written and erased, but never executed.

Once init-done has been seen, the configuration is frozen until reset.

Top module: `fbank_guard`

## Requirements
- R1: After reset the swap policy is disabled, the bank select is 0, no response or violation is pending, `arr_valid` is low and `req_ready` is high.
- R2: A configuration write with `cfg_sel`=0 loads the policy enable from `cfg_wdata[KEY_W]` only when `cfg_wdata[KEY_W-1:0]` equals the key 0xCA. A write with any other key leaves the policy unchanged.
- R3: While the policy is disabled, every access of every type is granted in both phases, and the physical address equals the logical address.
- R4: A write with `cfg_sel`=1 loads the bank select from `cfg_wdata[KEY_W]`, and no key is needed. The logical bank is the top address bit. The physical bank is the logical bank XOR (policy enabled AND bank select). The lower address bits pass through unchanged.
- R5: Before init-done has been sampled, every access type is granted everywhere, even with the policy enabled.
- R6: After init-done with the policy enabled, logical bank 0 grants read and fetch and denies write and erase.
- R7: After init-done with the policy enabled, logical bank 1 grants read, write and erase and denies fetch.
- R8: Init-done is sticky until reset. Once it has been sampled, later writes to either configuration register are ignored.
- R9: A denied access gives `rsp_grant`=0 and a one-cycle `viol_flag`. `viol_addr` and `viol_type` carry the logical address and type of that access, and `arr_valid` stays low.
- R10: The type codes are 00 read, 01 fetch, 10 write and 11 erase. A request is accepted on a clock edge where both `req_valid` and `req_ready` are high. Its result (`rsp_valid`, `rsp_grant`, `arr_*`, `viol_*`) appears at the next clock edge, and `rsp_valid` is low in any cycle that follows no acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Register select: 0 = policy, 1 = bank select |
| cfg_wdata | input | KEY_W+1 | Bit KEY_W holds the value; the low KEY_W bits hold the key |
| init_done | input | 1 | End-of-boot event (sticky) |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Guard can accept a request |
| req_type | input | 2 | Access type code |
| req_addr | input | ADDR_W | Logical address |
| rsp_valid | output | 1 | Decision valid |
| rsp_grant | output | 1 | Access granted |
| arr_valid | output | 1 | Forwarded access strobe to the array |
| arr_addr | output | ADDR_W | Physical address |
| arr_type | output | 2 | Forwarded access type |
| viol_flag | output | 1 | One-cycle access violation |
| viol_addr | output | ADDR_W | Logical address of the violating access |
| viol_type | output | 2 | Type of the violating access |

## Verification
Each access decision is due exactly one clock edge after the request is accepted. The bench drives each request on a falling edge and checks every response field on the next falling edge. On the falling edge after that it checks that `rsp_valid`, `viol_flag` and `arr_valid` have dropped again.

A configuration write or an init-done pulse only affects requests accepted at later edges. For this reason the bench always places at least one idle cycle between such a change and the next sweep.

Every address of a 4-bit address space is crossed with every access type. The bench repeats this sweep for each combination of policy, bank select and phase, and computes the expected grant and physical address from the requirements.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
   localparam logic [1:0] ACC_READ  = 2'b00;
   localparam logic [1:0] ACC_FETCH = 2'b01;
   localparam logic [1:0] ACC_WRITE = 2'b10;
   localparam logic [1:0] ACC_ERASE = 2'b11;

   typedef struct packed {
      logic       pol_en;
      logic       bank_sel;
      logic       init_seen;
   } fbg_state_t;
endpackage

// File: rtl/fbg_cfg.sv
module fbg_cfg #(
   parameter int unsigned KEY_W   = 8,
   parameter logic [KEY_W-1:0] KEY_VAL = 8'hCA
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic                  cfg_sel,
   input  logic [KEY_W:0]        cfg_wdata,
   input  logic                  init_done,
   output fbg_pkg::fbg_state_t   st
);
   localparam int unsigned VAL_BIT = KEY_W;

   logic pol_q, sel_q, init_q;
   logic key_ok, wr_pol, wr_sel;

   initial begin
      if (KEY_W < 1) $error("fbg_cfg: KEY_W must be at least 1");
   end

   assign key_ok = (cfg_wdata[KEY_W-1:0] == KEY_VAL);
   assign wr_pol = cfg_we && !init_q && !cfg_sel && key_ok;
   assign wr_sel = cfg_we && !init_q &&  cfg_sel;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pol_q  <= 1'b0;
         sel_q  <= 1'b0;
         init_q <= 1'b0;
      end else begin
         if (wr_pol) pol_q <= cfg_wdata[VAL_BIT];
         if (wr_sel) sel_q <= cfg_wdata[VAL_BIT];
         if (init_done) init_q <= 1'b1;
      end
   end

   assign st.pol_en    = pol_q;
   assign st.bank_sel  = sel_q;
   assign st.init_seen = init_q;

   a_r8_init_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      init_q |=> init_q);
   a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      init_q |=> ($stable(pol_q) && $stable(sel_q)));
   a_r2_bad_key_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_sel && (cfg_wdata[KEY_W-1:0] != KEY_VAL)) |=> $stable(pol_q));
endmodule

// File: rtl/fbg_remap.sv
module fbg_remap #(
   parameter int unsigned ADDR_W       = 16,
   parameter bit          SWAP_SUPPORT = 1'b1
) (
   input  logic [ADDR_W-1:0] laddr,
   input  logic              pol_en,
   input  logic              bank_sel,
   output logic              lbank,
   output logic [ADDR_W-1:0] paddr
);
   localparam int unsigned OFS_W = ADDR_W - 1;

   logic pbank;

   initial begin
      if (ADDR_W < 2) $error("fbg_remap: ADDR_W must be at least 2");
   end

   assign lbank = laddr[ADDR_W-1];

   generate
      if (SWAP_SUPPORT) begin : g_swap
         assign pbank = lbank ^ (pol_en & bank_sel);
      end else begin : g_fixed
         logic unused_cfg;
         assign unused_cfg = pol_en ^ bank_sel;
         assign pbank = lbank;
      end
   endgenerate

   assign paddr = {pbank, laddr[OFS_W-1:0]};
endmodule

// File: rtl/fbg_perm.sv
module fbg_perm
   import fbg_pkg::*;
(
   input  logic       run_phase,
   input  logic       lbank,
   input  logic [1:0] acc_type,
   output logic       grant
);
   logic exec_ok, store_ok;

   always_comb begin
      exec_ok  = (acc_type == ACC_READ) || (acc_type == ACC_FETCH);
      store_ok = (acc_type != ACC_FETCH);
      if (!run_phase)  grant = 1'b1;
      else if (!lbank) grant = exec_ok;
      else             grant = store_ok;
   end
endmodule

// File: rtl/fbank_guard.sv
module fbank_guard
   import fbg_pkg::*;
#(
   parameter int unsigned ADDR_W       = 16,
   parameter int unsigned KEY_W        = 8,
   parameter logic [KEY_W-1:0] KEY_VAL = 8'hCA,
   parameter bit          SWAP_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [KEY_W:0]    cfg_wdata,
   input  logic              init_done,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_type,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   output logic              rsp_grant,
   output logic              arr_valid,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [1:0]        arr_type,
   output logic              viol_flag,
   output logic [ADDR_W-1:0] viol_addr,
   output logic [1:0]        viol_type
);
   fbg_state_t        st;
   logic              lbank, grant_c, accept, ready_q;
   logic [ADDR_W-1:0] paddr;

   initial begin
      if (ADDR_W < 2)  $error("fbank_guard: ADDR_W must be at least 2");
      if (KEY_W < 1)   $error("fbank_guard: KEY_W must be at least 1");
   end

   fbg_cfg #(.KEY_W(KEY_W), .KEY_VAL(KEY_VAL)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .init_done(init_done), .st(st));

   fbg_remap #(.ADDR_W(ADDR_W), .SWAP_SUPPORT(SWAP_SUPPORT)) u_remap (
      .laddr(req_addr), .pol_en(st.pol_en), .bank_sel(st.bank_sel),
      .lbank(lbank), .paddr(paddr));

   fbg_perm u_perm (
      .run_phase(st.init_seen && st.pol_en), .lbank(lbank),
      .acc_type(req_type), .grant(grant_c));

   assign req_ready = ready_q;
   assign accept    = req_valid && ready_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ready_q   <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_grant <= 1'b0;
         arr_valid <= 1'b0;
         arr_addr  <= '0;
         arr_type  <= ACC_READ;
         viol_flag <= 1'b0;
         viol_addr <= '0;
         viol_type <= ACC_READ;
      end else begin
         ready_q   <= 1'b1;
         rsp_valid <= accept;
         rsp_grant <= accept && grant_c;
         arr_valid <= accept && grant_c;
         viol_flag <= accept && !grant_c;
         if (accept && grant_c) begin
            arr_addr <= paddr;
            arr_type <= req_type;
         end
         if (accept && !grant_c) begin
            viol_addr <= req_addr;
            viol_type <= req_type;
         end
      end
   end

   a_r9_no_forward_on_violation: assert property (@(posedge clk) disable iff (!rst_n)
      viol_flag |-> (!arr_valid && !rsp_grant && rsp_valid));
   a_r10_one_cycle_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> rsp_valid);
   a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_ready) |=> (!rsp_valid && !viol_flag && !arr_valid));
   a_r5_boot_all_granted: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !st.init_seen) |=> rsp_grant);
   a_r6_exec_bank_no_store: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && st.init_seen && st.pol_en && !req_addr[ADDR_W-1]
       && req_type[1]) |=> viol_flag);
   a_r7_data_bank_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && st.init_seen && st.pol_en && req_addr[ADDR_W-1]
       && (req_type == ACC_FETCH)) |=> viol_flag);
endmodule

// File: tb/sim_fbank_guard.sv
`timescale 1ns/1ps
module sim_fbank_guard;
   localparam int AW = 4;
   localparam int KW = 8;

   logic clk = 1'b0;
   logic rst_n, cfg_we, cfg_sel, init_done, req_valid;
   logic [KW:0]   cfg_wdata;
   logic [1:0]    req_type;
   logic [AW-1:0] req_addr;
   logic req_ready, rsp_valid, rsp_grant, arr_valid, viol_flag;
   logic [AW-1:0] arr_addr, viol_addr;
   logic [1:0]    arr_type, viol_type;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   fbank_guard #(.ADDR_W(AW), .KEY_W(KW), .KEY_VAL(8'hCA), .SWAP_SUPPORT(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .init_done(init_done), .req_valid(req_valid),
      .req_ready(req_ready), .req_type(req_type), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .arr_valid(arr_valid),
      .arr_addr(arr_addr), .arr_type(arr_type), .viol_flag(viol_flag),
      .viol_addr(viol_addr), .viol_type(viol_type));

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
      init_done = 1'b0; req_valid = 1'b0; req_type = 2'b00; req_addr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic cfg_write(input bit sel, input bit val, input logic [KW-1:0] key);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = {val, key};
      @(negedge clk);
      cfg_we = 1'b0;
      @(negedge clk);
   endtask

   task automatic pulse_init();
      init_done = 1'b1;
      @(negedge clk);
      init_done = 1'b0;
      @(negedge clk);
   endtask

   // Sweep every address and type; pol/sel/post describe the expected model.
   task automatic sweep(input string tag, input bit pol, input bit sel, input bit post);
      for (int a = 0; a < (1 << AW); a++) begin
         for (int t = 0; t < 4; t++) begin
            logic lb, g;
            logic [AW-1:0] pa;
            lb = a[AW-1];
            pa = {lb ^ (pol & sel), a[AW-2:0]};
            if (!post)   g = 1'b1;
            else if (!lb) g = (t == 0) || (t == 1);
            else          g = (t != 1);
            req_valid = 1'b1; req_addr = a[AW-1:0]; req_type = t[1:0];
            @(negedge clk);
            req_valid = 1'b0;
            if (g)
               check($sformatf("%s grant a=%0d t=%0d", tag, a, t),
                     {56'd0, rsp_valid, rsp_grant, viol_flag, arr_valid, arr_addr},
                     {56'd0, 1'b1, 1'b1, 1'b0, 1'b1, pa});
            else
               check($sformatf("%s R9 deny a=%0d t=%0d", tag, a, t),
                     {52'd0, rsp_valid, rsp_grant, viol_flag, arr_valid, viol_addr, 2'b00, viol_type},
                     {52'd0, 1'b1, 1'b0, 1'b1, 1'b0, a[AW-1:0], 2'b00, t[1:0]});
            @(negedge clk);
            check($sformatf("R10 R9 idle after a=%0d t=%0d", a, t),
                  {61'd0, rsp_valid, viol_flag, arr_valid}, 64'd0);
         end
      end
   endtask

   initial begin
      #1_500_000;
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1 reset state
      check("R1 reset outputs", {59'd0, rsp_valid, viol_flag, arr_valid, rsp_grant, req_ready},
            {59'd0, 5'b00001});
      // R3 disabled policy, identity mapping; R10 type codes exercised
      sweep("R3 R10 disabled", 1'b0, 1'b0, 1'b0);
      // R4 bank select has no effect while policy is off
      cfg_write(1'b1, 1'b1, 8'h00);
      sweep("R4 R3 sel without policy", 1'b0, 1'b1, 1'b0);
      // R2 wrong key is ignored
      cfg_write(1'b0, 1'b1, 8'hC5);
      cfg_write(1'b0, 1'b1, 8'h35);
      sweep("R2 bad key", 1'b0, 1'b1, 1'b0);
      // R2 correct key; R5 boot phase grants everything; R4 swap mapping
      cfg_write(1'b0, 1'b1, 8'hCA);
      sweep("R2 R4 R5 boot swapped", 1'b1, 1'b1, 1'b0);
      // R6 R7 run phase
      pulse_init();
      sweep("R6 R7 run swapped", 1'b1, 1'b1, 1'b1);
      // R8 writes after init ignored
      cfg_write(1'b0, 1'b0, 8'hCA);
      cfg_write(1'b1, 1'b0, 8'h00);
      pulse_init();
      sweep("R8 frozen", 1'b1, 1'b1, 1'b1);
      // R6 R7 run phase with default mapping
      do_reset();
      cfg_write(1'b0, 1'b1, 8'hCA);
      pulse_init();
      sweep("R6 R7 run direct", 1'b1, 1'b0, 1'b1);
      // R3 disabled in run phase; R8 enable after init ignored
      do_reset();
      pulse_init();
      cfg_write(1'b0, 1'b1, 8'hCA);
      sweep("R3 R8 run disabled", 1'b0, 1'b0, 1'b0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule